// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This block turns parallel data words into a continuous serial stream of fixed 14-bit frames. Each frame carries one 12-bit word, sent least significant bit first, followed by two fixed boundary bits (a one, then a zero) that let a receiver find frame alignment. A forwarded bit clock travels with the data. Serial data changes on the falling edge of the internal bit clock, so it is stable around each rising edge of the forwarded clock.

The block runs on a single bit clock at 14 times the word reference rate. New words are announced on a word-strobe input, which runs no faster than the reference rate and may be slower. The strobe passes through a two-flop synchronizer, and its rising edge is detected in the bit-clock domain. The captured word waits in a one-entry buffer until the next frame boundary. A frame that starts with no buffered word carries zero data, and its boundary bits are still present. Transmission needs three things at once: clock lock, a non-zero mode select (zero means power-down) and the direction input set to transmit. Without all three, the outputs stay low.

Top module: `framed_word_tx`

## Requirements
- R1: Every frame is 14 forwarded-clock periods long. Its 1st to 12th bits are data bits 0 to 11 in that order. Its 13th bit is 1 and its 14th bit is 0.
- R2: While transmission is enabled, frames follow one another with no gap. `ser_clk_o` gives one rising edge per bit-clock cycle, and the first rising edge after enable carries bit 1 of the first frame.
- R3: A strobe rising edge captures `data_i`, which must be held for at least 3 bit-clock cycles after that edge. The captured word is sent in the first frame that starts after the capture.
- R4: A frame that starts with no captured word pending carries 12 zero data bits, with normal boundary bits.
- R5: While `lock_i` is 0, `ser_o` stays 0 and `ser_clk_o` gives no edges.
- R6: While `mode_sel` is 2'b00 (power-down), `ser_o` stays 0 and `ser_clk_o` gives no edges.
- R7: While `dir_i` is 0, `ser_o` stays 0 and `ser_clk_o` gives no edges.
- R8: Strobes that arrive while transmission is disabled are discarded. The first frames after enable carry zero data.
- R9: A second strobe that arrives before the buffered word has been loaded sets `overrun_o`, which stays set until reset. The newer word replaces the older one, and only the newer word is sent.
- R10: During reset, `ser_o`, `ser_clk_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, 14 times the word reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Clock source locked |
| mode_sel | input | 2 | Operating mode; 2'b00 is power-down |
| dir_i | input | 1 | 1 = transmit, 0 = transmit path disabled |
| strobe_i | input | 1 | Word strobe, rising edge captures data |
| data_i | input | 12 | Parallel data word |
| ser_o | output | 1 | Serial frame data, changes on falling bit-clock edge |
| ser_clk_o | output | 1 | Forwarded bit clock, gated by enable |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The assertions check on every cycle the rules that hold at all times. The boundary bits must sit at their frame positions. The forwarded clock must run whenever a frame is active. Outputs must go quiet one cycle after lock, mode or direction removes the enable. The buffer must be emptied while disabled, and the overrun flag must stay set once raised. Some behaviour only the bench scenarios can show. These are the data bit order, which word lands in which frame, filler frames on missing strobes, replacement of a word on overrun, and the alignment of the first frame after enable.

// File: rtl/framed_word_tx.sv
module framed_word_tx #(
  parameter int DW = 12
) (
  input  logic          clk_bit,
  input  logic          rst_n,
  input  logic          lock_i,
  input  logic [1:0]    mode_sel,
  input  logic          dir_i,
  input  logic          strobe_i,
  input  logic [DW-1:0] data_i,
  output logic          ser_o,
  output logic          ser_clk_o,
  output logic          overrun_o
);
  localparam int FW = DW + 2;
  localparam int CW = $clog2(FW);

  logic [CW-1:0] cnt;
  logic          act;
  logic [FW-1:0] frame;
  logic [DW-1:0] buf_w;
  logic          buf_v;
  logic          ovr_q;
  logic [2:0]    stb_s;
  logic          ser_q;
  logic          gate_q;
  logic          en;
  logic          rise;
  logic          last;
  logic          load;

  assign en   = lock_i & dir_i & (|mode_sel);
  assign rise = stb_s[1] & ~stb_s[2];
  assign last = (cnt == CW'(FW - 1));
  assign load = en & (~act | last);

  always_ff @(posedge clk_bit or negedge rst_n)
    if (!rst_n) stb_s <= '0;
    else        stb_s <= {stb_s[1:0], strobe_i};

  always_ff @(posedge clk_bit or negedge rst_n)
    if (!rst_n) begin
      act   <= 1'b0;
      cnt   <= '0;
      frame <= '0;
    end else if (!en) begin
      act   <= 1'b0;
      cnt   <= '0;
      frame <= '0;
    end else if (load) begin
      act   <= 1'b1;
      cnt   <= '0;
      frame <= {2'b01, buf_v ? buf_w : {DW{1'b0}}};
    end else begin
      cnt   <= cnt + 1'b1;
    end

  always_ff @(posedge clk_bit or negedge rst_n)
    if (!rst_n) begin
      buf_w <= '0;
      buf_v <= 1'b0;
      ovr_q <= 1'b0;
    end else if (!en) begin
      buf_v <= 1'b0;
    end else begin
      if (load) buf_v <= 1'b0;
      if (rise) begin
        buf_w <= data_i;
        buf_v <= 1'b1;
        if (buf_v && !load) ovr_q <= 1'b1;
      end
    end

  always_ff @(negedge clk_bit or negedge rst_n)
    if (!rst_n) begin
      ser_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      ser_q  <= act ? frame[cnt] : 1'b0;
      gate_q <= act;
    end

  assign ser_o     = ser_q;
  assign ser_clk_o = clk_bit & gate_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/framed_word_tx_chk.sv
module framed_word_tx_chk #(
  parameter int FW = 14
) (
  input logic                  clk_bit,
  input logic                  rst_n,
  input logic                  lock_i,
  input logic                  dir_i,
  input logic [1:0]            mode_sel,
  input logic                  act,
  input logic [$clog2(FW)-1:0] cnt,
  input logic                  gate_q,
  input logic                  ser_o,
  input logic                  buf_v,
  input logic                  overrun_o
);
  AST_QUIET_NO_LOCK: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !lock_i |=> (!ser_o && !gate_q)); // R5
  AST_QUIET_PWRDN: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (mode_sel == 2'b00) |=> (!ser_o && !gate_q)); // R6
  AST_QUIET_DIR: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !dir_i |=> (!ser_o && !gate_q)); // R7
  AST_MARK_ONE: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (act && cnt == ($clog2(FW))'(FW - 2)) |-> ser_o); // R1
  AST_MARK_ZERO: assert property (@(posedge clk_bit) disable iff (!rst_n)
    (act && cnt == ($clog2(FW))'(FW - 1)) |-> !ser_o); // R1
  AST_CLK_FORWARD: assert property (@(posedge clk_bit) disable iff (!rst_n)
    act |-> gate_q); // R2
  AST_DROP_OFF: assert property (@(posedge clk_bit) disable iff (!rst_n)
    !(lock_i && dir_i && mode_sel != 2'b00) |=> !buf_v); // R8
  AST_OVR_STICKY: assert property (@(posedge clk_bit) disable iff (!rst_n)
    overrun_o |=> overrun_o); // R9
endmodule

bind framed_word_tx framed_word_tx_chk #(.FW(FW)) i_chk (
  .clk_bit(clk_bit), .rst_n(rst_n), .lock_i(lock_i), .dir_i(dir_i),
  .mode_sel(mode_sel), .act(act), .cnt(cnt), .gate_q(gate_q),
  .ser_o(ser_o), .buf_v(buf_v), .overrun_o(overrun_o)
);

// File: tb/test_framed_word_tx.sv
`timescale 1ns/1ps
module test_framed_word_tx;
  logic clk = 1'b0, rst_n = 1'b0, lock_i = 1'b0, dir_i = 1'b0, strobe_i = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [11:0] data_i = '0;
  logic ser_o, ser_clk_o, overrun_o;

  framed_word_tx i_framed_word_tx (.clk_bit(clk), .rst_n(rst_n), .lock_i(lock_i),
    .mode_sel(mode_sel), .dir_i(dir_i), .strobe_i(strobe_i), .data_i(data_i),
    .ser_o(ser_o), .ser_clk_o(ser_clk_o), .overrun_o(overrun_o));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0, edges = 0, rx_bits = 0, rx_n = 0;
  logic [13:0] rx_sh = '0;
  logic [13:0] rx_frames [0:31];
  bit done = 1'b0;

  always @(posedge ser_clk_o) begin
    edges++;
    rx_sh = {ser_o, rx_sh[13:1]};
    rx_bits++;
    if (rx_bits == 14) begin
      if (rx_n < 32) rx_frames[rx_n] = rx_sh;
      rx_n++;
      rx_bits = 0;
    end
  end

  // {ovr_expected, strobe_count, word1, word2, expected_data}
  localparam logic [38:0] VEC [8] = '{
    {1'b0, 2'd1, 12'hA5C, 12'h000, 12'hA5C},
    {1'b0, 2'd1, 12'h001, 12'h000, 12'h001},
    {1'b0, 2'd0, 12'hFFF, 12'h000, 12'h000},
    {1'b0, 2'd1, 12'hFFF, 12'h000, 12'hFFF},
    {1'b0, 2'd1, 12'h800, 12'h000, 12'h800},
    {1'b0, 2'd0, 12'h3C3, 12'h000, 12'h000},
    {1'b1, 2'd2, 12'h123, 12'h456, 12'h456},
    {1'b1, 2'd1, 12'h7E1, 12'h000, 12'h7E1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic rx_clear();
    edges = 0; rx_bits = 0; rx_n = 0;
  endtask

  task automatic pulse(input logic [11:0] w);
    data_i = w; strobe_i = 1'b1; cyc(4);
    strobe_i = 1'b0; cyc(4);
  endtask

  task automatic run_entry(input logic [1:0] ns, input logic [11:0] w1, input logic [11:0] w2);
    for (int c = 0; c < 14; c++) begin
      strobe_i = ((ns >= 2'd1) && c < 4) || ((ns == 2'd2) && c >= 7 && c < 10);
      data_i   = (c < 7) ? w1 : w2;
      @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    lock_i = 1'b1; dir_i = 1'b1; mode_sel = 2'b01;
    cyc(3);
    #1.5;
    chk("R10 ser_o in reset", 32'(ser_o), 0);
    chk("R10 ser_clk_o in reset", 32'(ser_clk_o), 0);
    chk("R10 overrun_o in reset", 32'(overrun_o), 0);
    chk("R10 no edges in reset", edges, 0);
    dir_i = 1'b0; lock_i = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    cyc(3);

    // R5: lock low
    rx_clear(); dir_i = 1'b1; mode_sel = 2'b01; lock_i = 1'b0;
    pulse(12'h5A5); cyc(20);
    chk("R5 no edges without lock", edges, 0);
    chk("R5 ser_o low without lock", 32'(ser_o), 0);

    // R6: power-down
    lock_i = 1'b1; mode_sel = 2'b00; cyc(2); rx_clear();
    pulse(12'hA5A); cyc(20);
    chk("R6 no edges in power-down", edges, 0);
    chk("R6 ser_o low in power-down", 32'(ser_o), 0);

    // R7, R8: direction off, strobe discarded
    dir_i = 1'b0; mode_sel = 2'b10; cyc(2); rx_clear();
    pulse(12'hABC); cyc(12);
    chk("R7 no edges with dir 0", edges, 0);
    chk("R7 ser_o low with dir 0", 32'(ser_o), 0);
    rx_clear();
    dir_i = 1'b1;
    @(posedge clk); #1;
    edges = 0;
    cyc(42);
    chk("R2 one edge per bit clock", edges, 42);
    chk("R2 three whole frames", rx_n, 3);
    chk("R8 discarded word, frame 0", 32'(rx_frames[0]), 32'h1000);
    chk("R8 discarded word, frame 1", 32'(rx_frames[1]), 32'h1000);
    dir_i = 1'b0; cyc(6);

    // R1 R3 R4 R9: vector walk
    rx_clear(); mode_sel = 2'b01;
    dir_i = 1'b1;
    @(posedge clk); #1;
    for (int i = 0; i < 8; i++) begin
      run_entry(VEC[i][37:36], VEC[i][35:24], VEC[i][23:12]);
      chk("R9 overrun flag", 32'(overrun_o), 32'(VEC[i][38]));
    end
    strobe_i = 1'b0;
    cyc(20);
    chk("R2 frames received in walk", 32'(rx_n >= 9), 1);
    chk("R4 R1 filler first frame", 32'(rx_frames[0]), 32'h1000);
    for (int k = 1; k < 9; k++)
      chk("R1 R3 R4 R9 frame content", 32'(rx_frames[k]), 32'({2'b01, VEC[k-1][11:0]}));
    dir_i = 1'b0; cyc(4);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule